// File: doc/BRIEF.md
# Interpolating gamma palette with auto-increment loader

This block holds a small color lookup memory that a pixel pipeline uses to remap each of three 10-bit components. Software fills the memory through two registers: a pointer register that carries the entry number and two mode flags, and a data register. Each data word is a packed entry of three 10-bit values. When the auto-step flag is on, every data write advances the pointer, so a whole table loads as one burst of data writes. Three 16-bit ceiling registers, one per channel, supply the output for inputs at or above full scale.

On the pixel side every component is looked up separately. The upper bits of the component pick an entry and the lower bits interpolate linearly toward the next entry. In split mode the lower half of the memory is a first-stage table whose result feeds a second-stage table in the upper half. The result appears one cycle later as a 16-bit value.

Top module: `gamma_palette`

## Requirements
- R1: After reset, entry i of every channel holds floor(i*1023/(DEPTH-1)). Each ceiling register holds 0xFFFF. The pointer is 0, auto-step and split are off, out_valid is 0 and all outputs are 0.
- R2: A write with reg_sel=1 stores reg_wdata[29:0] into the entry at the pointer. Red is bits 29:20, green bits 19:10 and blue bits 9:0.
- R3: When auto-step is on, each data write advances the pointer by one, wrapping from DEPTH-1 to 0. When it is off, the pointer does not move.
- R4: A pointer write (reg_sel=0) with bit 31 set turns auto-step on and sets split mode from bit 30. The pointer field bits in that same word are ignored.
- R5: A pointer write with bit 31 clear turns auto-step off, sets split from bit 30 and loads the pointer from bits AW-1:0. A word of all zeros therefore clears both modes and the pointer.
- R6: Writes with reg_sel=2, 3 or 4 load bits 15:0 into the red, green or blue ceiling register.
- R7: out_valid is pix_valid delayed by one cycle. The outputs keep their values in cycles that follow a cycle without pix_valid.
- R8: When split is off, component x[9:0] picks entry i=x[9:10-AW] with fraction f=x[9-AW:0]. The result is y=e(i)+floor((e(i+1)-e(i))*f/2^(10-AW)). For the last entry, e(i+1) is taken as e(i). The output is y*64.
- R9: When split is on, x first goes through the same interpolation over entries 0..DEPTH/2-1 using AW-1 index bits. That 10-bit result then goes through entries DEPTH/2..DEPTH-1 in the same way, and the output is the second result times 64.
- R10: An input component with bit 10 set, which is at or above full scale, produces that channel's ceiling register value. The table is not used for it.
- R11: A lookup in the same cycle as a register write uses the memory, the modes and the ceilings as they stood before that write.
- R12: Writes with reg_sel of 5, 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 pointer, 1 data, 2/3/4 red/green/blue ceiling |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | 11 | Red component, U1.10 |
| pix_g | input | 11 | Green component, U1.10 |
| pix_b | input | 11 | Blue component, U1.10 |
| out_valid | output | 1 | Result valid |
| out_r | output | 16 | Red result |
| out_g | output | 16 | Green result |
| out_b | output | 16 | Blue result |

## Verification
The hardest cases to reach from the ports are the pointer wrapping past the last entry and the ignored pointer field in a word that enables auto-step. Neither can be read back directly. The stimulus loads a full table in one burst, adds one extra data write, and then looks up entry 0, where the wrapped write must appear. A second pass writes the same entry twice with auto-step off and probes its neighbours. A random phase mixes pointer, data and ceiling writes with lookups in the same cycles, so that falling table segments, split chaining and write-before-read ordering are compared every cycle against the reference model.

// File: rtl/gamma_palette.sv
module gamma_palette #(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        pix_valid,
  input  logic [10:0] pix_r,
  input  logic [10:0] pix_g,
  input  logic [10:0] pix_b,
  output logic        out_valid,
  output logic [15:0] out_r,
  output logic [15:0] out_g,
  output logic [15:0] out_b
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam int HW    = AW - 1;
  localparam int FB    = 10 - AW;
  localparam int FBH   = 10 - HW;

  logic [29:0]   mem [DEPTH];
  logic [AW-1:0] idx;
  logic          auto_inc, split_on;
  logic [15:0]   maxv [3];
  logic [10:0]   pin  [3];
  logic [9:0]    dg   [3];
  logic [9:0]    gv   [3];
  logic [15:0]   res  [3];
  logic [15:0]   oreg [3];

  wire wr_idx  = reg_we && reg_sel == 3'd0;
  wire wr_data = reg_we && reg_sel == 3'd1;

  assign pin[2] = pix_r;
  assign pin[1] = pix_g;
  assign pin[0] = pix_b;
  assign out_r = oreg[2];
  assign out_g = oreg[1];
  assign out_b = oreg[0];

  function automatic logic [9:0] lin_entry(input int i);
    return 10'((i * 1023) / (DEPTH - 1));
  endfunction

  function automatic logic [9:0] seg_lookup(input int ch, input logic upper,
                                            input logic half, input logic [9:0] x);
    logic [AW-1:0] i0, i1;
    logic [9:0] lo, hi;
    logic last;
    int f, fb, d;
    if (half) begin
      i0   = {upper, x[9:FBH]};
      f    = int'(x[FBH-1:0]);
      fb   = FBH;
      last = (x[9:FBH] == HW'(HALF - 1));
    end else begin
      i0   = x[9:FB];
      f    = int'(x[FB-1:0]);
      fb   = FB;
      last = (i0 == AW'(DEPTH - 1));
    end
    i1 = last ? i0 : AW'(i0 + 1'b1);
    lo = mem[i0][ch*10 +: 10];
    hi = mem[i1][ch*10 +: 10];
    d  = int'(hi) - int'(lo);
    return 10'(int'(lo) + ((d * f) >>> fb));
  endfunction

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      dg[c]  = split_on ? seg_lookup(c, 1'b0, 1'b1, pin[c][9:0]) : pin[c][9:0];
      gv[c]  = split_on ? seg_lookup(c, 1'b1, 1'b1, dg[c])
                        : seg_lookup(c, 1'b0, 1'b0, pin[c][9:0]);
      res[c] = pin[c][10] ? maxv[c] : {gv[c], 6'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      auto_inc  <= 1'b0;
      split_on  <= 1'b0;
      out_valid <= 1'b0;
      for (int c = 0; c < 3; c++) begin
        maxv[c] <= 16'hFFFF;
        oreg[c] <= '0;
      end
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= {lin_entry(i), lin_entry(i), lin_entry(i)};
    end else begin
      out_valid <= pix_valid;
      if (pix_valid)
        for (int c = 0; c < 3; c++) oreg[c] <= res[c];
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin
            split_on <= reg_wdata[30];
            auto_inc <= reg_wdata[31];
            if (!reg_wdata[31]) idx <= reg_wdata[AW-1:0];
          end
          3'd1: begin
            mem[idx] <= reg_wdata[29:0];
            if (auto_inc) idx <= AW'(idx + 1'b1);
          end
          3'd2: maxv[2] <= reg_wdata[15:0];
          3'd3: maxv[1] <= reg_wdata[15:0];
          3'd4: maxv[0] <= reg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));
  assert_clamp_red_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_r[10] |=> out_r == $past(maxv[2]));
  assert_table_grain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_g[10] |=> out_g[5:0] == 6'd0);
  assert_auto_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && auto_inc |=> idx == AW'($past(idx) + 1'b1));
  assert_field_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx && reg_wdata[31] |=> $stable(idx) && auto_inc);
  assert_plain_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx && !reg_wdata[31] |=> !auto_inc && idx == $past(reg_wdata[AW-1:0]));
endmodule

// File: tb/gamma_palette_bench.sv
module gamma_palette_bench;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, pix_valid = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [10:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic out_valid;
  logic [15:0] out_r, out_g, out_b;

  int checks = 0, errors = 0;
  bit done = 0;

  int tab [3][DEPTH];
  int mx [3];
  int m_idx, m_out [3];
  bit m_auto, m_split, m_valid;

  always #5 clk = ~clk;

  gamma_palette #(.AW(AW)) u_gamma_palette (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  function automatic int ref_seg(int ch, int base, int bits, int x);
    int fb = 10 - bits;
    int n = 1 << bits;
    int i = x >> fb;
    int f = x % (1 << fb);
    int lo = tab[ch][base + i];
    int hi = (i == n - 1) ? lo : tab[ch][base + i + 1];
    return lo + (((hi - lo) * f) >>> fb);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        mx[c] = 65535; m_out[c] = 0;
        for (int i = 0; i < DEPTH; i++) tab[c][i] = (i * 1023) / (DEPTH - 1);
      end
      m_idx = 0; m_auto = 0; m_split = 0; m_valid = 0;
    end else begin
      int px [3];
      px[0] = int'(pix_r); px[1] = int'(pix_g); px[2] = int'(pix_b);
      m_valid = pix_valid;
      if (pix_valid)
        for (int c = 0; c < 3; c++) begin
          if (px[c] >= 1024) m_out[c] = mx[c];
          else if (m_split)
            m_out[c] = 64 * ref_seg(c, DEPTH / 2, AW - 1, ref_seg(c, 0, AW - 1, px[c]));
          else m_out[c] = 64 * ref_seg(c, 0, AW, px[c]);
        end
      if (reg_we) begin
        if (reg_sel == 0) begin
          m_split = reg_wdata[30];
          m_auto = reg_wdata[31];
          if (!reg_wdata[31]) m_idx = int'(reg_wdata[AW-1:0]);
        end else if (reg_sel == 1) begin
          tab[0][m_idx] = int'(reg_wdata[29:20]);
          tab[1][m_idx] = int'(reg_wdata[19:10]);
          tab[2][m_idx] = int'(reg_wdata[9:0]);
          if (m_auto) m_idx = (m_idx + 1) % DEPTH;
        end else if (reg_sel >= 2 && reg_sel <= 4) mx[reg_sel - 2] = int'(reg_wdata[15:0]);
      end
    end
  end

  task automatic cycle(string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== m_valid || int'(out_r) != m_out[0] || int'(out_g) != m_out[1]
        || int'(out_b) != m_out[2]) begin
      errors++;
      $display("FAIL %s: got v=%0b %0d %0d %0d expected v=%0b %0d %0d %0d", tag,
               out_valid, out_r, out_g, out_b, m_valid, m_out[0], m_out[1], m_out[2]);
    end
    reg_we = 0; pix_valid = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, string tag);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    cycle(tag);
  endtask

  task automatic px(input int r, input int g, input int b, string tag);
    pix_valid = 1; pix_r = 11'(r); pix_g = 11'(g); pix_b = 11'(b);
    cycle(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cycle("R1 reset");
    rst_n = 1;
    cycle("R1 idle");
    for (int i = 0; i < DEPTH; i += 5) px(i * 32, i * 32 + 31, 1023, "R1 default table");
    px(37, 500, 999, "R8 default interp");
    cycle("R7 hold");
    cycle("R7 hold");
    wr(0, 32'h0, "R5 clear");
    wr(0, 32'h8000_0005, "R4 auto on, index ignored");
    for (int k = 0; k < DEPTH; k++)
      wr(1, {2'b0, 10'(k * k), 10'(1023 - k * 33), 10'((k * 157) % 1024)}, "R2 burst");
    for (int k = 0; k < DEPTH; k++) px(k * 32 + 7, k * 32 + 19, k * 32 + 31, "R8 loaded");
    wr(1, {2'b0, 10'd900, 10'd5, 10'd600}, "R3 wrap write");
    px(0, 16, 31, "R3 wrapped to entry 0");
    px(1023, 1000, 992, "R8 last entry");
    wr(0, 32'h0000_0007, "R5 pointer load");
    wr(1, {2'b0, 10'd100, 10'd200, 10'd300}, "R3 no step");
    wr(1, {2'b0, 10'd111, 10'd222, 10'd333}, "R3 no step");
    px(7 * 32, 8 * 32, 6 * 32, "R3 entry 7 overwritten");
    px(7 * 32 + 16, 8 * 32 + 3, 7 * 32 + 31, "R8 around 7");
    wr(2, 32'hFFFF_1234, "R6 red ceiling");
    wr(3, 32'h0000_ABCD, "R6 green ceiling");
    wr(4, 32'h0000_0042, "R6 blue ceiling");
    px(1024, 2047, 1500, "R10 over range");
    px(1024, 300, 2047, "R10 mixed");
    wr(5, 32'hFFFF_FFFF, "R12 unused");
    wr(7, 32'h0, "R12 unused");
    px(1024, 1025, 100, "R12 ceilings kept");
    wr(0, 32'h4000_0000, "R9 split on");
    for (int k = 0; k < 1024; k += 97) px(k, 1023 - k, (k * 7) % 1024, "R9 split chain");
    px(1023, 0, 512, "R9 split ends");
    reg_we = 1; reg_sel = 0; reg_wdata = 32'h0;
    pix_valid = 1; pix_r = 11'd300; pix_g = 11'd700; pix_b = 11'd5;
    cycle("R11 split off same cycle");
    px(300, 700, 5, "R5 split cleared");
    reg_we = 1; reg_sel = 1; reg_wdata = {2'b0, 10'd1, 10'd2, 10'd3};
    pix_valid = 1; pix_r = 11'd0; pix_g = 11'd0; pix_b = 11'd0;
    cycle("R11 data same cycle");
    px(0, 0, 0, "R11 data visible after");
    reg_we = 1; reg_sel = 2; reg_wdata = 32'h0000_0077;
    pix_valid = 1; pix_r = 11'd1024;
    cycle("R11 ceiling same cycle");
    px(1024, 0, 0, "R6 ceiling after");
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 8;
      if (op < 3) begin
        reg_we = 1;
        reg_sel = (op == 0) ? 3'(($urandom % 2 == 0) ? 0 : 2 + $urandom % 6) : 3'd1;
        reg_wdata = $urandom;
      end
      if ($urandom % 3 != 0) begin
        pix_valid = 1;
        pix_r = 11'($urandom % 1100); pix_g = 11'($urandom % 1100); pix_b = 11'($urandom % 1100);
      end
      cycle("R9 R8 random mix");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule